// File: doc/BRIEF.md
# 16-to-8-bit bus cycle converter

This block connects a 16-bit processor bus, which has no transfer-size signal, to an ISA-style expansion bus whose targets may be one or two bytes wide. For each processor request it presents the address and the active-low byte-high enable. It then pulses the command strobe that matches the request: memory read, memory write, I/O read or I/O write. While the strobe is active it samples the target's 16-bit acknowledge. The acknowledge it samples is the memory one for memory cycles and the I/O one for I/O cycles.

A wide target completes in a single word cycle on both lanes. A narrow target is served on the low lane only. An odd-address byte is moved between the low expansion lane and the high processor lane. A full word is split into two byte cycles with one idle clock between them. The second cycle uses the odd address and has byte-high disabled. The low byte read in the first cycle is held in a register while the second cycle runs. The processor sees ready low for the whole sequence. Ready then pulses for one clock with the assembled data. A target-ready input held low stretches the command phase of either byte cycle.

The processor holds `cpu_req` and the request fields steady until it sees `cpu_ready`. A request is taken only while the converter is idle. The byte-high enable and A0 select the access: word (`cpu_bhe`=1, A0=0), low byte (`cpu_bhe`=0, A0=0) or high byte (`cpu_bhe`=1, A0=1).

Top module: `bus_size_bridge`

## Requirements
- R1: During and right after synchronous reset, all four command strobes and `bus_sbhe_n` are high, and `cpu_ready` and `bus_dout_en` are low.
- R2: The expansion address and `bus_sbhe_n` (equal to the inverse of `cpu_bhe`) are valid at least one clock before the first command strobe falls, and they do not change while it is active.
- R3: The width decision uses `bus_memcs16_n` for memory cycles and `bus_iocs16_n` for I/O cycles. A low level on the acknowledge that does not match the cycle type has no effect.
- R4: With a wide target, every access takes exactly one strobe pulse. Read data on both lanes goes straight to `cpu_rdata`, and a write drives the low CPU byte on the low lane (A0=0) and the high CPU byte on the high lane. The strobe is the one that matches the request: memory read, memory write, I/O read or I/O write.
- R5: With a narrow target and a high-byte access, one strobe pulse runs on the low lane. A read places `bus_din[7:0]` into `cpu_rdata[15:8]`, and a write drives `cpu_wdata[15:8]` onto `bus_dout[7:0]`.
- R6: With a narrow target and a word access, two strobe pulses run. The second one has address bit 0 set and `bus_sbhe_n` high. The high CPU byte is written on the low lane, and a read returns {second byte, first byte}.
- R7: `cpu_ready` stays low for the whole access and is never high while a strobe is active. It is then high for exactly one clock with the final read data.
- R8: While `bus_rdy` is low, the command phase of the current byte cycle holds, with the strobe active and `cpu_ready` low. With `bus_rdy` high, each strobe pulse lasts exactly two clocks.
- R9: With a narrow target and a low-byte access, one strobe pulse runs with no steering: `bus_din[7:0]` goes to `cpu_rdata[7:0]`, and `cpu_wdata[7:0]` goes to `bus_dout[7:0]`.
- R10: Between the two byte cycles of a split access, all strobes are inactive for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_addr | input | AW | Byte address, bit 0 is A0 |
| cpu_bhe | input | 1 | High byte enable, active high |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_wdata | input | 2*BW | Write data, both lanes |
| cpu_ready | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 2*BW | Assembled read data |
| bus_addr | output | AW | Expansion address |
| bus_sbhe_n | output | 1 | High byte enable, active low |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_dout | output | 2*BW | Write data toward the targets |
| bus_dout_en | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 2*BW | Read data from the targets |
| bus_memcs16_n | input | 1 | Wide-target acknowledge for memory, active low |
| bus_iocs16_n | input | 1 | Wide-target acknowledge for I/O, active low |
| bus_rdy | input | 1 | Target ready, low stretches the command phase |

## Verification
The width decision and a stretch from the target can fall in the same clock. Target ready can be released in the very clock in which the 16-bit acknowledge is judged, and a stretch can also land in the second byte cycle after the split has been decided. The random part provokes both. It drops `bus_rdy` on random clocks across byte accesses, word accesses, both widths and both spaces, and it chooses addresses whose memory-width and I/O-width bits differ. Each access is judged by its strobe count, by the address and byte-high enable of every pulse, and by the gap between pulses. The read data or the target's stored bytes are also compared with a reference byte array that the bench keeps.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_ADDR       = 3'd1,
    S_CMD        = 3'd2,
    S_SAMPLE16   = 3'd3,
    S_BYTE1_DONE = 3'd4,
    S_BYTE2_CMD  = 3'd5,
    S_BYTE2_DONE = 3'd6,
    S_READY_CPU  = 3'd7
  } bsb_state_e;

  // strobe index = {io, wr}: 0 mem read, 1 mem write, 2 io read, 3 io write
  localparam int NSTRB = 4;
endpackage

// File: rtl/bsb_seq.sv
module bsb_seq
  import bsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rdy,
  input  logic       wide,
  input  logic       word,
  output bsb_state_e st_q,
  output bsb_state_e st_d
);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:       if (start) st_d = S_ADDR;
      S_ADDR:       st_d = S_CMD;
      S_CMD:        if (rdy) st_d = S_SAMPLE16;
      S_SAMPLE16:   st_d = (wide || !word) ? S_READY_CPU : S_BYTE1_DONE;
      S_BYTE1_DONE: st_d = S_BYTE2_CMD;
      S_BYTE2_CMD:  if (rdy) st_d = S_BYTE2_DONE;
      S_BYTE2_DONE: st_d = S_READY_CPU;
      S_READY_CPU:  st_d = S_IDLE;
      default:      st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_IDLE;
    else     st_q <= st_d;
  end

  // R6: a split only ever comes from the sizing sample of the first cycle
  a_r6_split_origin: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_BYTE1_DONE) |-> $past(st_q) == S_SAMPLE16);

endmodule

// File: rtl/bsb_lane.sv
module bsb_lane
  import bsb_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 8
) (
  input  bsb_state_e          st_d,
  input  bsb_state_e          st_q,
  input  logic [AW-1:0]       addr,
  input  logic                bhe,
  input  logic                wr,
  input  logic                io,
  input  logic [2*BW-1:0]     wdata,
  input  logic                wide,
  input  logic [2*BW-1:0]     din,
  input  logic [2*BW-1:0]     rdata_q,
  output logic [AW-1:0]       addr_nx,
  output logic                sbhe_n_nx,
  output logic [NSTRB-1:0]    strb_n_nx,
  output logic [2*BW-1:0]     dout_nx,
  output logic                doe_nx,
  output logic [2*BW-1:0]     rdata_d
);

  localparam int DW = 2 * BW;

  logic strobe_on, second, first_addr;
  logic [BW-1:0] wlo, whi, dlo;

  assign wlo = wdata[BW-1:0];
  assign whi = wdata[DW-1:BW];
  assign dlo = din[BW-1:0];

  assign strobe_on  = (st_d == S_CMD) || (st_d == S_SAMPLE16) ||
                      (st_d == S_BYTE2_CMD) || (st_d == S_BYTE2_DONE);
  assign second     = (st_d == S_BYTE1_DONE) || (st_d == S_BYTE2_CMD) ||
                      (st_d == S_BYTE2_DONE);
  assign first_addr = (st_d == S_ADDR) || (st_d == S_CMD) || (st_d == S_SAMPLE16);

  assign addr_nx   = second ? (addr | {{(AW-1){1'b0}}, 1'b1}) : addr;
  assign sbhe_n_nx = first_addr ? ~bhe : 1'b1;
  assign dout_nx   = {whi, (second || addr[0]) ? whi : wlo};
  assign doe_nx    = wr && (first_addr || second);

  for (genvar g = 0; g < NSTRB; g++) begin : g_strb
    assign strb_n_nx[g] = ~(strobe_on && ({io, wr} == 2'(g)));
  end

  always_comb begin
    rdata_d = rdata_q;
    if (!wr) begin
      if (st_q == S_SAMPLE16) begin
        if (wide)         rdata_d = din;
        else if (addr[0]) rdata_d = {dlo, rdata_q[BW-1:0]};
        else              rdata_d = {rdata_q[DW-1:BW], dlo};
      end else if (st_q == S_BYTE2_DONE) begin
        rdata_d = {dlo, rdata_q[BW-1:0]};
      end
    end
  end

endmodule

// File: rtl/bus_size_bridge.sv
module bus_size_bridge
  import bsb_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_bhe,
  input  logic              cpu_wr,
  input  logic              cpu_io,
  input  logic [2*BW-1:0]   cpu_wdata,
  output logic              cpu_ready,
  output logic [2*BW-1:0]   cpu_rdata,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_sbhe_n,
  output logic              bus_memr_n,
  output logic              bus_memw_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  output logic [2*BW-1:0]   bus_dout,
  output logic              bus_dout_en,
  input  logic [2*BW-1:0]   bus_din,
  input  logic              bus_memcs16_n,
  input  logic              bus_iocs16_n,
  input  logic              bus_rdy
);

  localparam int DW = 2 * BW;

  bsb_state_e st_q, st_d;
  logic start, wide, word;
  logic [AW-1:0] addr_q, addr_d;
  logic bhe_q, bhe_d, wr_q, wr_d, io_q, io_d;
  logic [DW-1:0] wd_q, wd_d;

  logic [AW-1:0]    addr_nx;
  logic             sbhe_n_nx, doe_nx;
  logic [NSTRB-1:0] strb_n_nx;
  logic [DW-1:0]    dout_nx, rdata_d;

  assign start  = (st_q == S_IDLE) && cpu_req;
  assign addr_d = start ? cpu_addr  : addr_q;
  assign bhe_d  = start ? cpu_bhe   : bhe_q;
  assign wr_d   = start ? cpu_wr    : wr_q;
  assign io_d   = start ? cpu_io    : io_q;
  assign wd_d   = start ? cpu_wdata : wd_q;

  assign wide = io_q ? ~bus_iocs16_n : ~bus_memcs16_n;
  assign word = bhe_q && !addr_q[0];

  bsb_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .rdy   (bus_rdy),
    .wide  (wide),
    .word  (word),
    .st_q  (st_q),
    .st_d  (st_d)
  );

  bsb_lane #(.AW(AW), .BW(BW)) u_lane (
    .st_d      (st_d),
    .st_q      (st_q),
    .addr      (addr_d),
    .bhe       (bhe_d),
    .wr        (wr_d),
    .io        (io_d),
    .wdata     (wd_d),
    .wide      (wide),
    .din       (bus_din),
    .rdata_q   (cpu_rdata),
    .addr_nx   (addr_nx),
    .sbhe_n_nx (sbhe_n_nx),
    .strb_n_nx (strb_n_nx),
    .dout_nx   (dout_nx),
    .doe_nx    (doe_nx),
    .rdata_d   (rdata_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      bhe_q       <= 1'b0;
      wr_q        <= 1'b0;
      io_q        <= 1'b0;
      wd_q        <= '0;
      bus_addr    <= '0;
      bus_sbhe_n  <= 1'b1;
      {bus_iow_n, bus_ior_n, bus_memw_n, bus_memr_n} <= '1;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
    end else begin
      addr_q      <= addr_d;
      bhe_q       <= bhe_d;
      wr_q        <= wr_d;
      io_q        <= io_d;
      wd_q        <= wd_d;
      bus_addr    <= addr_nx;
      bus_sbhe_n  <= sbhe_n_nx;
      {bus_iow_n, bus_ior_n, bus_memw_n, bus_memr_n} <= strb_n_nx;
      bus_dout    <= dout_nx;
      bus_dout_en <= doe_nx;
      cpu_ready   <= (st_d == S_READY_CPU);
      cpu_rdata   <= rdata_d;
    end
  end

  logic strobe_act;
  assign strobe_act = ~&{bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n};

  // R2: address and byte-high enable settle before the strobe falls
  a_r2_addr_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_act) |-> $stable(bus_addr) && $stable(bus_sbhe_n));

  // R7: ready never overlaps a strobe
  a_r7_no_ready_in_cmd: assert property (@(posedge clk) disable iff (rst)
    strobe_act |-> !cpu_ready);

  // R7: ready is a single-clock pulse
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R8: a low target-ready holds the command phase
  a_r8_stretch: assert property (@(posedge clk) disable iff (rst)
    (strobe_act && !bus_rdy && (st_q == S_CMD || st_q == S_BYTE2_CMD))
      |=> strobe_act && !cpu_ready);

  // R10: a strobe that ends without completion is followed by one idle clock
  a_r10_one_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(strobe_act) && !cpu_ready) |=> strobe_act);

  // R6: the second byte cycle targets the odd byte with byte-high disabled
  a_r6_second_addr: assert property (@(posedge clk) disable iff (rst)
    (strobe_act && st_q == S_BYTE2_CMD) |-> bus_addr[0] && bus_sbhe_n);

endmodule

// File: tb/sim_bus_size_bridge.sv
module sim_bus_size_bridge;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cpu_req = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic        cpu_bhe = 1'b0, cpu_wr = 1'b0, cpu_io = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic [19:0] bus_addr;
  logic        bus_sbhe_n, bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n;
  logic [15:0] bus_dout, bus_din;
  logic        bus_dout_en, bus_memcs16_n, bus_iocs16_n;
  logic        bus_rdy = 1'b1;

  bus_size_bridge u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_bhe(cpu_bhe), .cpu_wr(cpu_wr), .cpu_io(cpu_io), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_addr(bus_addr),
    .bus_sbhe_n(bus_sbhe_n), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_memcs16_n(bus_memcs16_n),
    .bus_iocs16_n(bus_iocs16_n), .bus_rdy(bus_rdy)
  );

  // target model: memory width from address bit 8, I/O width from bit 9
  logic [7:0] tmem [0:511];
  logic [7:0] refm [0:511];
  logic [7:0] junk = 8'h5a;
  logic rd_act, wr_act, io_cyc, w16;
  logic [8:0] ev, od, bi;

  assign bus_memcs16_n = ~bus_addr[8];
  assign bus_iocs16_n  = ~bus_addr[9];
  assign rd_act = ~bus_memr_n | ~bus_ior_n;
  assign wr_act = ~bus_memw_n | ~bus_iow_n;
  assign io_cyc = ~bus_ior_n | ~bus_iow_n;
  assign w16    = io_cyc ? bus_addr[9] : bus_addr[8];
  assign ev = {io_cyc, bus_addr[7:1], 1'b0};
  assign od = {io_cyc, bus_addr[7:1], 1'b1};
  assign bi = {io_cyc, bus_addr[7:0]};
  assign bus_din = (rd_act && w16) ? {tmem[od], tmem[ev]} :
                   rd_act ? {junk, tmem[bi]} : {junk, junk};

  function automatic logic [7:0] initv(input int i);
    return 8'(i * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) tmem[i] <= initv(i);
    end else if (wr_act) begin
      if (w16) begin
        if (!bus_addr[0]) tmem[ev] <= bus_dout[7:0];
        if (!bus_sbhe_n)  tmem[od] <= bus_dout[15:8];
      end else begin
        tmem[bi] <= bus_dout[7:0];
      end
    end
  end

  always @(negedge clk) junk <= 8'($urandom);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic xfer(input logic io, input logic wr, input logic [19:0] a,
                      input logic bhe, input logic [15:0] wd,
                      input int hold, input bit rnd);
    int k, pulses, len1, gap, overlap;
    bit act, prev, done;
    logic sbhe1, sbhe2;
    logic [19:0] a1, a2;
    logic [3:0] kind1, expkind;
    logic [15:0] rd;
    logic wide_t, word_t;
    logic [8:0] e, o;
    wide_t = io ? a[9] : a[8];
    word_t = bhe && !a[0];
    e = {io, a[7:1], 1'b0};
    o = {io, a[7:1], 1'b1};
    expkind = ~(4'b0001 << {io, wr});
    pulses = 0; len1 = 0; gap = 0; overlap = 0; prev = 0; done = 0;
    sbhe1 = 1; sbhe2 = 0; a1 = '0; a2 = '0; kind1 = '1; rd = '0; k = 0;
    @(negedge clk);
    cpu_io = io; cpu_wr = wr; cpu_addr = a; cpu_bhe = bhe; cpu_wdata = wd;
    cpu_req = 1'b1;
    bus_rdy = (hold > 0) ? 1'b0 : 1'b1;
    while (!done) begin
      @(negedge clk);
      k++;
      act = ~&{bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n};
      if (act && !prev) begin
        pulses++;
        if (pulses == 1) begin
          sbhe1 = bus_sbhe_n; a1 = bus_addr;
          kind1 = {bus_iow_n, bus_ior_n, bus_memw_n, bus_memr_n};
        end
        if (pulses == 2) begin a2 = bus_addr; sbhe2 = bus_sbhe_n; end
      end
      if (act && pulses == 1) len1++;
      if (!act && pulses == 1 && !cpu_ready) gap++;
      if (act && cpu_ready) overlap++;
      prev = act;
      if (hold > 0 && k == hold)
        chk(act && !cpu_ready, "R8 strobe held while target not ready", {act, cpu_ready}, 2'b10);
      if (cpu_ready) begin
        done = 1; rd = cpu_rdata; cpu_req = 1'b0;
      end
      if (k < hold) bus_rdy = 1'b0;
      else bus_rdy = rnd ? (($urandom % 3) != 0) : 1'b1;
      if (k > 400) begin
        chk(0, "R7 watchdog: no completion", k, 0);
        done = 1; cpu_req = 1'b0;
      end
    end
    bus_rdy = 1'b1;
    chk(pulses == ((!wide_t && word_t) ? 2 : 1), "R3 R4 R6 R9 strobe pulse count",
        pulses, (!wide_t && word_t) ? 2 : 1);
    chk(kind1 == expkind, "R4 strobe type", kind1, expkind);
    chk(sbhe1 == ~bhe && a1 == a, "R2 first address and SBHE", {a1, 3'b0, sbhe1}, {a, 3'b0, ~bhe});
    chk(overlap == 0, "R7 ready during strobe", overlap, 0);
    if (!rnd && hold == 0)
      chk(len1 == 2, "R8 pulse length with target ready", len1, 2);
    if (pulses == 2) begin
      chk(a2 == (a | 20'h1) && sbhe2 == 1'b1, "R6 second cycle address/SBHE",
          {a2, 3'b0, sbhe2}, {a | 20'h1, 4'b0001});
      chk(gap == 1, "R10 idle clocks between byte cycles", gap, 1);
    end
    if (wr) begin
      if (!a[0]) refm[e] = wd[7:0];
      if (bhe)   refm[o] = wd[15:8];
      chk({tmem[o], tmem[e]} == {refm[o], refm[e]},
          wide_t ? "R4 wide write" : (!a[0] && bhe) ? "R6 split write" :
          a[0] ? "R5 odd byte write" : "R9 even byte write",
          {tmem[o], tmem[e]}, {refm[o], refm[e]});
    end else begin
      if (!a[0])
        chk(rd[7:0] == refm[e], wide_t ? "R4 wide read low" :
            bhe ? "R6 split read low" : "R9 even byte read", rd[7:0], refm[e]);
      if (bhe)
        chk(rd[15:8] == refm[o], wide_t ? "R4 wide read high" :
            a[0] ? "R5 odd byte read" : "R6 split read high", rd[15:8], refm[o]);
    end
    @(negedge clk);
    chk(!cpu_ready, "R7 ready lasts one clock", cpu_ready, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 512; i++) refm[i] = initv(i);
    repeat (3) @(negedge clk);
    chk({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_sbhe_n} == 5'b11111 &&
        !cpu_ready && !bus_dout_en, "R1 state during reset",
        {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_sbhe_n, cpu_ready, bus_dout_en},
        7'b1111100);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk({bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_sbhe_n} == 5'b11111 &&
        !cpu_ready && !bus_dout_en, "R1 state after reset",
        {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_sbhe_n, cpu_ready, bus_dout_en},
        7'b1111100);
    // directed corner cases
    xfer(0, 0, 20'h00010, 1, 16'h0000, 0, 0);  // R6 narrow word read
    xfer(0, 1, 20'h00012, 1, 16'hbeef, 0, 0);  // R6 narrow word write
    xfer(0, 0, 20'h00012, 1, 16'h0000, 0, 0);
    xfer(0, 0, 20'h00110, 1, 16'h0000, 0, 0);  // R4 wide word read
    xfer(0, 1, 20'h00114, 1, 16'h1234, 0, 0);  // R4 wide word write
    xfer(0, 0, 20'h00021, 1, 16'h0000, 0, 0);  // R5 odd byte read
    xfer(0, 1, 20'h00033, 1, 16'ha5c3, 0, 0);  // R5 odd byte write
    xfer(0, 0, 20'h00044, 0, 16'h0000, 0, 0);  // R9 even byte read
    xfer(0, 1, 20'h00046, 0, 16'h9977, 0, 0);  // R9 even byte write
    xfer(1, 0, 20'h00150, 1, 16'h0000, 0, 0);  // R3 io, memory-width bit set: narrow
    xfer(1, 1, 20'h00152, 1, 16'h4321, 0, 0);  // R3
    xfer(1, 0, 20'h00250, 1, 16'h0000, 0, 0);  // R3 io wide
    xfer(0, 0, 20'h00250, 1, 16'h0000, 0, 0);  // R3 memory narrow despite io-width bit
    xfer(0, 1, 20'h00161, 1, 16'hc0de, 0, 0);  // R4 wide odd byte write
    xfer(0, 0, 20'h00018, 1, 16'h0000, 8, 0);  // R8 stretched split read
    xfer(1, 1, 20'h00220, 1, 16'h7e7e, 8, 0);  // R8 stretched wide write
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [19:0] ra;
      logic rbhe;
      int kind;
      kind = int'($urandom % 3);
      ra = {8'($urandom), 2'($urandom), 8'($urandom), 1'b0};
      ra = {ra[19:1], (kind == 2) ? 1'b1 : 1'b0};
      rbhe = (kind != 1);
      xfer(1'($urandom), 1'($urandom), ra, rbhe, 16'($urandom), 0, 1);
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R7 global watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule